// File: doc/BRIEF.md
# Command/Indication Channel Interface

This block connects a host register bus to the 4-bit command/indication channel of a layer-1 line transceiver. The host writes a command register whose 4-bit code drives the outgoing channel, and reads back a status register that carries the most recently accepted incoming indication along with change flags. Incoming codes pass through a frame-rate filter. A code is accepted only after two consecutive frame samples agree. Each accepted change raises a flag and an interrupt source bit.

A primary and a secondary incoming channel are watched. The secondary code can be read through its own register. Some command choices are made by the block itself. A reset request chooses between deactivate and reset from the present indication. An incoming error indication is answered with deactivate without host action. A one-pulse initialisation sequence issues reset, clears the interrupt mask and then issues deactivate.

Top module: `ci_port`

## Requirements
- R1: After reset, ci_out is 4'hF (DI), the mask register reads 8'hFF, and the status register reads 8'h3C (latched indication 4'hF, no flags). The command register reads 8'h3F, the ISR reads 8'h00 and irq is 0.
- R2: A host write to address 0 (CMD) sets ci_out to bus_wdata[5:2] one cycle later. Reading CMD returns the code in bits 5:2 with bits 1:0 forced to 1 and bits 7:6 zero.
- R3: An incoming code is accepted only when two consecutive frame_tick samples agree and differ from the latched code. A value present for a single frame is ignored.
- R4: The status register at address 1 holds the latched primary indication in bits 5:2, the primary change flag in bit 1 and the secondary change flag in bit 0. Address 2 returns the latched secondary code in bits 5:2.
- R5: Reading the status register clears both change flags.
- R6: ISR bit 2 (address 3, value 8'h04) is set while either change flag is set. All other ISR bits read 0.
- R7: irq is the OR of the ISR bits not masked by the mask register at address 4. A mask of 8'hFF blocks every source.
- R8: On rst_req, the command becomes DI (4'hF) if the latched indication is EI1 (4'h6) or DR (4'h0), and RES (4'h1) otherwise.
- R9: When the primary indication becomes EI1 (4'h6), the command becomes DI (4'hF) in the same cycle, unless a higher-priority command source acts.
- R10: An init_req pulse sets the command to RES on the next edge, clears the mask one edge later, and sets the command to DI on the edge after that.
- R11: Command sources are ranked, highest first: the init sequence, then a host write, then rst_req, then the automatic EI1 answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| frame_tick | input | 1 | One pulse per line frame; samples the incoming codes |
| ci_pri_in | input | 4 | Incoming primary indication code |
| ci_sec_in | input | 4 | Incoming secondary code |
| rst_req | input | 1 | Reset request; command chosen by R8 |
| init_req | input | 1 | Starts the initialisation sequence |
| ci_out | output | 4 | Outgoing command code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default address width of 3. With that width all five registers are reachable and the read path is exercised end to end. A scoreboard queue holds expected read data. The stimulus walks the indication through a one-frame glitch, a real change, deactivate-request and error-indication values, which brings both branches of the reset rule and the automatic answer within reach. A host write in the same cycle as a reset request exercises the source ranking.

// File: rtl/ci_pkg.sv
// Package: shared codes, register addresses and field positions for the
// command/indication channel interface. Assumes 4-bit codes and an 8-bit bus.
package ci_pkg;
    localparam int CODE_W = 4;
    localparam int DATA_W = 8;
    localparam int NCH    = 2;     // primary and secondary incoming channels
    localparam int ISR_CI = 2;     // ISR bit raised by a C/I change

    typedef logic [CODE_W-1:0] ci_code_t;

    localparam ci_code_t CMD_RES = 4'h1;
    localparam ci_code_t CMD_DI  = 4'hF;
    localparam ci_code_t IND_EI1 = 4'h6;
    localparam ci_code_t IND_DR  = 4'h0;
    localparam ci_code_t IND_RST = 4'hF;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_SEC  = 3'd2;
    localparam logic [2:0] A_ISR  = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;

    typedef enum logic [1:0] {SQ_IDLE, SQ_UNMASK, SQ_DI} seq_e;
endpackage

// File: rtl/ci_filter.sv
// Module: two-frame agreement filter for one incoming C/I code.
// Samples din on each tick; accepts a value once two successive samples
// match and differ from the held code. Assumes tick is a one-cycle pulse.
module ci_filter #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] code,
    output logic         chg
);
    logic [W-1:0] smp_q;

    // Acceptance: current sample equals previous sample and is new
    assign chg = tick && (din == smp_q) && (din != code);

    // Keep last sample and the accepted code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= RST_VAL;
            code  <= RST_VAL;
        end else if (tick) begin
            smp_q <= din;
            if (chg) code <= din;
        end
    end
endmodule

// File: rtl/ci_cmd.sv
// Module: outgoing command register with source ranking, reset rule,
// automatic deactivate answer and the three-step init sequence.
// Assumes cur_ind is the accepted primary indication.
module ci_cmd
    import ci_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     host_wr,
    input  ci_code_t host_code,
    input  logic     rst_req,
    input  logic     init_req,
    input  ci_code_t cur_ind,
    input  logic     pri_chg,
    input  ci_code_t pri_new,
    output ci_code_t cmd,
    output logic     seq_busy,
    output logic     seq_unmask
);
    seq_e st_q;
    logic rst_to_di;

    // Reset rule: deactivate when already in error or deactivation
    assign rst_to_di  = (cur_ind == IND_EI1) || (cur_ind == IND_DR);
    assign seq_busy   = (st_q != SQ_IDLE);
    assign seq_unmask = (st_q == SQ_UNMASK);

    // Command register and init sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd  <= CMD_DI;
            st_q <= SQ_IDLE;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (init_req) begin
                        cmd  <= CMD_RES;
                        st_q <= SQ_UNMASK;
                    end else if (host_wr) begin
                        cmd <= host_code;
                    end else if (rst_req) begin
                        cmd <= rst_to_di ? CMD_DI : CMD_RES;
                    end else if (pri_chg && (pri_new == IND_EI1)) begin
                        cmd <= CMD_DI;
                    end
                end
                SQ_UNMASK: st_q <= SQ_DI;
                default: begin
                    cmd  <= CMD_DI;
                    st_q <= SQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ci_port.sv
// Module: top of the C/I channel interface. Holds change flags, mask and
// registered read data; filters both incoming channels. Assumes one bus
// access per cycle and a registered read with one cycle of latency.
module ci_port
    import ci_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              frame_tick,
    input  logic [3:0]        ci_pri_in,
    input  logic [3:0]        ci_sec_in,
    input  logic              rst_req,
    input  logic              init_req,
    output logic [3:0]        ci_out,
    output logic              irq
);
    ci_code_t           ch_in   [NCH];
    ci_code_t           ch_code [NCH];
    logic [NCH-1:0]     ch_chg;
    logic [NCH-1:0]     flags_q;
    logic [DATA_W-1:0]  mask_q;
    logic [DATA_W-1:0]  isr;
    logic               seq_busy;
    logic               seq_unmask;
    logic               wr_cmd, wr_mask, rd_stat;

    assign ch_in[0] = ci_pri_in;
    assign ch_in[1] = ci_sec_in;

    // One agreement filter per incoming channel
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ci_filter #(.W(CODE_W), .RST_VAL(IND_RST)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (frame_tick),
            .din  (ch_in[g]),
            .code (ch_code[g]),
            .chg  (ch_chg[g])
        );
    end

    assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
    assign rd_stat = bus_rd && (bus_addr == ADDR_W'(A_STAT));

    ci_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (wr_cmd),
        .host_code (bus_wdata[5:2]),
        .rst_req   (rst_req),
        .init_req  (init_req),
        .cur_ind   (ch_code[0]),
        .pri_chg   (ch_chg[0]),
        .pri_new   (ch_in[0]),
        .cmd       (ci_out),
        .seq_busy  (seq_busy),
        .seq_unmask(seq_unmask)
    );

    // Change flags: set wins over clear-on-read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_chg[i])    flags_q[i] <= 1'b1;
                else if (rd_stat) flags_q[i] <= 1'b0;
            end
        end
    end

    // Mask register: init sequence clears it, host may write it
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '1;
        else if (seq_unmask) mask_q <= '0;
        else if (wr_mask)    mask_q <= bus_wdata;
    end

    // Interrupt status and request
    always_comb begin
        isr         = '0;
        isr[ISR_CI] = |flags_q;
    end
    assign irq = |(isr & ~mask_q);

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(A_CMD):  bus_rdata <= {2'b00, ci_out, 2'b11};
                ADDR_W'(A_STAT): bus_rdata <= {2'b00, ch_code[0], flags_q[0], flags_q[1]};
                ADDR_W'(A_SEC):  bus_rdata <= {2'b00, ch_code[1], 2'b00};
                ADDR_W'(A_ISR):  bus_rdata <= isr;
                ADDR_W'(A_MASK): bus_rdata <= mask_q;
                default:         bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ci_port_chk.sv
// Module: assertion checker for ci_port, attached by bind below.
module ci_port_chk
    import ci_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              frame_tick,
    input logic              rst_req,
    input logic              init_req,
    input logic [3:0]        ci_out,
    input logic              irq,
    input logic [3:0]        pri_code,
    input logic              seq_busy,
    input logic [7:0]        mask_q
);
    logic host_cmd;
    assign host_cmd = bus_wr && (bus_addr == ADDR_W'(A_CMD));

    // R2
    cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_cmd && !seq_busy && !init_req |=> ci_out == $past(bus_wdata[5:2]));

    // R3
    ind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(pri_code));

    // R7
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'hFF) |-> !irq);

    // R8
    rst_di_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && !host_cmd && !seq_busy && !init_req &&
        ((pri_code == IND_EI1) || (pri_code == IND_DR)) |=> ci_out == CMD_DI);

    // R8
    rst_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && !host_cmd && !seq_busy && !init_req &&
        (pri_code != IND_EI1) && (pri_code != IND_DR) |=> ci_out == CMD_RES);

    // R9
    auto_di_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_code == IND_EI1) && ($past(pri_code) != IND_EI1) &&
        $past(!host_cmd && !seq_busy && !init_req && !rst_req) |-> ci_out == CMD_DI);

    // R10
    init_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_req && !seq_busy |=> ci_out == CMD_RES);
endmodule

bind ci_port ci_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .frame_tick(frame_tick),
    .rst_req   (rst_req),
    .init_req  (init_req),
    .ci_out    (ci_out),
    .irq       (irq),
    .pri_code  (ch_code[0]),
    .seq_busy  (seq_busy),
    .mask_q    (mask_q)
);

// File: tb/ci_port_tb.sv
// Bench: scoreboard of expected read data plus direct output checks.
module ci_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_tick = 1'b0;
    logic [3:0] ci_pri_in = 4'hF, ci_sec_in = 4'hF;
    logic       rst_req = 1'b0, init_req = 1'b0;
    logic [3:0] ci_out;
    logic       irq;

    int total = 0;
    int bad   = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5ns clk = ~clk;

    ci_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_tick(frame_tick), .ci_pri_in(ci_pri_in), .ci_sec_in(ci_sec_in),
        .rst_req(rst_req), .init_req(init_req), .ci_out(ci_out), .irq(irq)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] stat_v(input logic [3:0] ind, input logic fp, input logic fs);
        return {2'b00, ind, fp, fs};
    endfunction

    // Monitor: compare read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk(bus_rdata, 8'hxx, "scoreboard empty");
            else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic frame(input logic [3:0] p, input logic [3:0] s);
        @(negedge clk); ci_pri_in = p; ci_sec_in = s; frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    task automatic pulse_rst;
        @(negedge clk); rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk({4'h0, ci_out}, 8'h0F, "R1 ci_out");
        chk({7'h0, irq}, 8'h00, "R1 irq");
        rd(3'd1, 8'h3C, "R1 status");
        rd(3'd4, 8'hFF, "R1 mask");
        rd(3'd0, 8'h3F, "R1 cmd");
        rd(3'd3, 8'h00, "R1 isr");
        // R2 host command
        wr(3'd0, 8'h20);
        chk({4'h0, ci_out}, 8'h08, "R2 ci_out");
        rd(3'd0, 8'h23, "R2 cmd readback");
        // R3 one-frame glitch ignored
        frame(4'h3, 4'hF);
        frame(4'hF, 4'hF);
        rd(3'd1, stat_v(4'hF, 0, 0), "R3 glitch");
        // R3 two agreeing frames accepted
        frame(4'h3, 4'hF);
        frame(4'h3, 4'hF);
        rd(3'd3, 8'h04, "R6 isr set");
        chk({7'h0, irq}, 8'h00, "R7 masked");
        wr(3'd4, 8'hFB);
        chk({7'h0, irq}, 8'h01, "R7 unmasked");
        rd(3'd1, stat_v(4'h3, 1, 0), "R3 R4 accepted");
        rd(3'd1, stat_v(4'h3, 0, 0), "R5 cleared");
        chk({7'h0, irq}, 8'h00, "R7 irq after clear");
        rd(3'd3, 8'h00, "R6 isr clear");
        // R4 secondary channel
        frame(4'h3, 4'h9);
        frame(4'h3, 4'h9);
        chk({7'h0, irq}, 8'h01, "R7 secondary irq");
        rd(3'd1, stat_v(4'h3, 0, 1), "R4 secondary flag");
        rd(3'd2, 8'h24, "R4 secondary code");
        // R8 reset rule, ordinary indication
        pulse_rst;
        chk({4'h0, ci_out}, 8'h01, "R8 res");
        frame(4'h0, 4'h9);
        frame(4'h0, 4'h9);
        wr(3'd0, 8'h20);
        pulse_rst;
        chk({4'h0, ci_out}, 8'h0F, "R8 di on DR");
        // R9 automatic answer to EI1
        wr(3'd0, 8'h20);
        frame(4'h6, 4'h9);
        chk({4'h0, ci_out}, 8'h08, "R9 before accept");
        frame(4'h6, 4'h9);
        chk({4'h0, ci_out}, 8'h0F, "R9 auto di");
        rd(3'd1, stat_v(4'h6, 1, 0), "R4 EI1 status");
        wr(3'd0, 8'h20);
        pulse_rst;
        chk({4'h0, ci_out}, 8'h0F, "R8 di on EI1");
        // R11 host write beats rst_req
        @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h24; rst_req = 1'b1;
        @(negedge clk); bus_wr = 1'b0; rst_req = 1'b0;
        chk({4'h0, ci_out}, 8'h09, "R11 ranking");
        // R10 init sequence
        wr(3'd4, 8'hFF);
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        chk({4'h0, ci_out}, 8'h01, "R10 res step");
        @(negedge clk);
        chk({4'h0, ci_out}, 8'h01, "R10 unmask step");
        @(negedge clk);
        chk({4'h0, ci_out}, 8'h0F, "R10 di step");
        rd(3'd4, 8'h00, "R10 mask cleared");
        repeat (3) @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "scoreboard drained");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule